// File: doc/BRIEF.md
# Streaming Hamming ECC Generator for NAND Page Chunks

This block computes a single-error-correcting Hamming code over fixed-size chunks of NAND page data while the bytes stream through the controller. Each accepted byte updates a running parity. The update runs only while the ECC enable is high, and it works the same whether data is being read from the flash or written to it. When the last byte of a chunk has been taken, the block releases the chunk's raw parity and a storage-format code word, and it restarts its accumulator for the next chunk without losing a cycle.

The raw parity has column parity in the low six bits and line parity above them. The storage word is the bitwise inverse of the raw parity shifted left by two bits, truncated to a whole number of bytes. After each result the block also sends that storage word out one byte per cycle, most significant byte first, so the bytes can be written straight into the spare area. In the write direction the result is released a fixed number of cycles later than in the read direction. A clear strobe discards any partial chunk before a new transfer begins.

Top module: `hamming_stream_ecc`

## Requirements
- R1: Every CHUNK_BYTES accepted bytes produce exactly one result: `res_done` is high for one cycle per chunk, and the next accepted byte starts a fresh chunk at index 0 with zero parity.
- R2: Raw bits [5:0] are column parity. Bit 2j+1 (j = 0..2) is the XOR, over every byte of the chunk, of the data bits whose bit position has bit j set. Bit 2j is the same XOR over the positions with bit j clear.
- R3: Raw bits [RAW_W-1:6] are line parity, with IDX_W = log2(CHUNK_BYTES) and RAW_W = 6 + 2*IDX_W - 1 (21 bits for 256-byte chunks). For k < IDX_W-1, bit 6+2k+1 is the XOR of the byte parities of the bytes whose chunk index has bit k set, and bit 6+2k is the same XOR over the bytes where that index bit is clear. The top bit is the XOR of the byte parities of the bytes whose highest index bit is set.
- R4: `res_store` equals the bitwise inverse of (raw << 2) over STORE_W bits. STORE_W = 8*ceil((RAW_W+2)/8), which is 24 for 256-byte chunks. Bits 1:0, and every bit above RAW_W+1, are therefore 1.
- R5: In the STORE_W/8 cycles that follow the `res_done` cycle, `code_valid` is high and `code_byte` carries the storage word, most significant byte first. `code_last` marks the final byte, and `code_valid` falls in the cycle after it.
- R6: `clr` sets the chunk index and the partial parity to zero. A byte presented in the same cycle as `clr` is discarded.
- R7: A byte contributes, and advances the chunk index, only when `in_valid` and `ecc_en` are both high. Bytes presented with `ecc_en` low, and cycles with `in_valid` low, change nothing.
- R8: When `dir_rd` is 1 at the final byte (read direction), `res_done` and `res_raw` appear in the cycle after that byte is accepted.
- R9: When `dir_rd` is 0 at the final byte (write direction), `res_done` appears WR_LAT cycles later than in the read direction. `res_raw` already holds the chunk's result at that point.
- R10: Within one chunk, every single-bit error position gives a distinct, nonzero raw parity, so one flipped bit per chunk can be located.
- R11: After reset, `res_done`, `code_valid` and `code_last` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Discards the partial chunk |
| ecc_en | input | 1 | Parity accumulation enable |
| dir_rd | input | 1 | Transfer direction: 1 read, 0 write |
| in_valid | input | 1 | A data byte is present |
| in_data | input | 8 | Data byte |
| res_done | output | 1 | One-cycle pulse when a chunk result is released |
| res_raw | output | RAW_W | Raw parity: line parity above column parity |
| res_store | output | STORE_W | Storage-format code word |
| code_valid | output | 1 | `code_byte` holds a storage byte |
| code_byte | output | 8 | Storage byte, most significant first |
| code_last | output | 1 | Final storage byte of the result |

## Verification
The bench builds the block with CHUNK_BYTES = 16 and WR_LAT = 3. This gives 13 raw bits and a 2-byte storage word. With that configuration, all 128 single-bit error positions in a chunk can be swept and their syndromes compared pairwise for distinctness. The short chunk also keeps randomized runs in both directions cheap, with disabled and idle bytes interleaved and a clear issued mid-chunk. Because WR_LAT is 3 rather than 0, the write-direction delay can be told apart from the read-direction timing by counting exact cycles.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } xfer_dir_e;

  // Mask of the bit positions inside a byte whose index bit j equals 'odd'.
  function automatic logic [7:0] col_mask(input int j, input logic odd);
    logic [7:0] m;
    for (int b = 0; b < 8; b++) begin
      m[b] = (((b >> j) & 1) == 1) ? odd : ~odd;
    end
    return m;
  endfunction

endpackage

// File: rtl/hecc_accum.sv
module hecc_accum #(
  parameter int CHUNK_BYTES = 256,
  parameter int IDX_W       = 8,
  parameter int RAW_W       = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ecc_en,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             fin,
  output logic [RAW_W-1:0] fin_raw
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHUNK_BYTES - 1);

  // Contribution of one byte at chunk index ix to the raw parity.
  function automatic logic [RAW_W-1:0] byte_term(input logic [7:0] d,
                                                 input logic [IDX_W-1:0] ix);
    logic [RAW_W-1:0] t;
    logic             bp;
    t  = '0;
    bp = ^d;
    for (int j = 0; j < 3; j++) begin
      t[2*j]   = ^(d & hecc_pkg::col_mask(j, 1'b0));
      t[2*j+1] = ^(d & hecc_pkg::col_mask(j, 1'b1));
    end
    for (int k = 0; k < IDX_W - 1; k++) begin
      t[6+2*k]   = bp & ~ix[k];
      t[6+2*k+1] = bp &  ix[k];
    end
    t[RAW_W-1] = bp & ix[IDX_W-1];
    return t;
  endfunction

  logic [RAW_W-1:0] acc;
  logic [IDX_W-1:0] idx;
  logic [RAW_W-1:0] term;
  logic             take;

  assign take    = in_valid & ecc_en & ~clr;
  assign term    = byte_term(in_data, idx);
  assign fin     = take && (idx == LAST_IDX);
  assign fin_raw = acc ^ term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      idx <= '0;
    end else if (clr) begin
      acc <= '0;
      idx <= '0;
    end else if (take) begin
      if (fin) begin
        acc <= '0;
        idx <= '0;
      end else begin
        acc <= acc ^ term;
        idx <= idx + IDX_W'(1);
      end
    end
  end

  // R6: a clear leaves an empty chunk behind
  p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (idx == '0) && (acc == '0));

  // R7: nothing moves without an enabled, valid byte
  p_idle_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(in_valid && ecc_en)) |=> ($stable(idx) && $stable(acc)));

  // R1: the final byte restarts the next chunk from zero
  p_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (idx == '0) && (acc == '0));

endmodule

// File: rtl/hecc_release.sv
module hecc_release #(
  parameter int RAW_W  = 21,
  parameter int WR_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fin,
  input  logic [RAW_W-1:0] fin_raw,
  input  logic             dir_rd,
  output logic             done,
  output logic [RAW_W-1:0] hold_raw
);

  localparam int CW = (WR_LAT > 0) ? $clog2(WR_LAT + 1) : 1;

  hecc_pkg::xfer_dir_e dir;
  logic                pend;
  logic [CW-1:0]       cnt;

  assign dir  = hecc_pkg::xfer_dir_e'(dir_rd);
  assign done = pend && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      cnt      <= '0;
      hold_raw <= '0;
    end else if (fin) begin
      hold_raw <= fin_raw;
      pend     <= 1'b1;
      cnt      <= (dir == hecc_pkg::DIR_READ) ? '0 : CW'(WR_LAT);
    end else if (pend) begin
      if (cnt == '0) pend <= 1'b0;
      else           cnt  <= cnt - CW'(1);
    end
  end

  // R8: read-direction result follows the final byte at once
  p_read_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && dir_rd) |=> done);

  // R1: a release lasts one cycle
  p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fin) |=> !done);

  // R9: the held result does not move while waiting
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !fin) |=> $stable(hold_raw));

  generate
    if (WR_LAT > 0) begin : g_wr_wait
      // R9: write-direction result is not released early
      p_write_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !dir_rd) |=> !done);
    end
  endgenerate

endmodule

// File: rtl/hecc_emit.sv
module hecc_emit #(
  parameter int STORE_B = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [8*STORE_B-1:0] word,
  output logic                 code_valid,
  output logic [7:0]           code_byte,
  output logic                 code_last
);

  localparam int W  = 8 * STORE_B;
  localparam int LW = $clog2(STORE_B + 1);

  logic [W-1:0]  sh;
  logic [LW-1:0] left;

  assign code_valid = (left != '0);
  assign code_last  = (left == LW'(1));
  assign code_byte  = sh[W-1 -: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
    end else if (load) begin
      sh   <= word;
      left <= LW'(STORE_B);
    end else if (left != '0) begin
      sh   <= sh << 8;
      left <= left - LW'(1);
    end
  end

  // R5: emission starts right after a release
  p_emit_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> code_valid);

  // R5: emission ends after the marked last byte
  p_emit_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (code_last && !load) |=> !code_valid);

endmodule

// File: rtl/hamming_stream_ecc.sv
module hamming_stream_ecc #(
  parameter int CHUNK_BYTES = 256,
  parameter int WR_LAT      = 2,
  localparam int IDX_W      = $clog2(CHUNK_BYTES),
  localparam int RAW_W      = 6 + 2 * IDX_W - 1,
  localparam int STORE_B    = (RAW_W + 2 + 7) / 8,
  localparam int STORE_W    = 8 * STORE_B
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               ecc_en,
  input  logic               dir_rd,
  input  logic               in_valid,
  input  logic [7:0]         in_data,
  output logic               res_done,
  output logic [RAW_W-1:0]   res_raw,
  output logic [STORE_W-1:0] res_store,
  output logic               code_valid,
  output logic [7:0]         code_byte,
  output logic               code_last
);

  // Flash storage form: inverse of the raw parity moved up two bits.
  function automatic logic [STORE_W-1:0] store_form(input logic [RAW_W-1:0] r);
    logic [STORE_W-1:0] wide;
    wide = {{(STORE_W - RAW_W){1'b0}}, r};
    return ~(wide << 2);
  endfunction

  logic             fin;
  logic [RAW_W-1:0] fin_raw;

  hecc_accum #(
    .CHUNK_BYTES (CHUNK_BYTES),
    .IDX_W       (IDX_W),
    .RAW_W       (RAW_W)
  ) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .ecc_en   (ecc_en),
    .in_valid (in_valid),
    .in_data  (in_data),
    .fin      (fin),
    .fin_raw  (fin_raw)
  );

  hecc_release #(
    .RAW_W  (RAW_W),
    .WR_LAT (WR_LAT)
  ) u_release (
    .clk      (clk),
    .rst_n    (rst_n),
    .fin      (fin),
    .fin_raw  (fin_raw),
    .dir_rd   (dir_rd),
    .done     (res_done),
    .hold_raw (res_raw)
  );

  assign res_store = store_form(res_raw);

  hecc_emit #(
    .STORE_B (STORE_B)
  ) u_emit (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (res_done),
    .word       (res_store),
    .code_valid (code_valid),
    .code_byte  (code_byte),
    .code_last  (code_last)
  );

  // R11: nothing is released or emitted straight out of reset
  p_reset_quiet_r11: assert property (@(posedge clk)
    !rst_n |=> (!res_done && !code_valid));

endmodule

// File: tb/test_hamming_stream_ecc.sv
module test_hamming_stream_ecc;

  localparam int CB = 16;
  localparam int WL = 3;
  localparam int IW = 4;
  localparam int RW = 6 + 2 * IW - 1;
  localparam int SB = (RW + 2 + 7) / 8;
  localparam int SW = 8 * SB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr = 1'b0;
  logic          ecc_en = 1'b0;
  logic          dir_rd = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = '0;
  logic          res_done;
  logic [RW-1:0] res_raw;
  logic [SW-1:0] res_store;
  logic          code_valid;
  logic [7:0]    code_byte;
  logic          code_last;

  hamming_stream_ecc #(.CHUNK_BYTES(CB), .WR_LAT(WL)) i_hamming_stream_ecc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ecc_en(ecc_en), .dir_rd(dir_rd),
    .in_valid(in_valid), .in_data(in_data), .res_done(res_done),
    .res_raw(res_raw), .res_store(res_store), .code_valid(code_valid),
    .code_byte(code_byte), .code_last(code_last)
  );

  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int n_done = 0;
  int n_chunks = 0;
  logic [31:0] seed = 32'h1234_5677;
  logic [7:0]  chunk [CB];
  logic [RW-1:0] sweep [128];

  always @(negedge clk) if (rst_n && res_done) n_done++;

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // Bit-by-bit reference: each set data bit flips one column bit per
  // position-bit pair and one line bit per index-bit pair.
  function automatic logic [RW-1:0] ref_raw();
    logic [RW-1:0] r;
    r = '0;
    for (int i = 0; i < CB; i++) begin
      for (int b = 0; b < 8; b++) begin
        if (chunk[i][b]) begin
          for (int j = 0; j < 3; j++) r[2*j + ((b >> j) & 1)] ^= 1'b1;
          for (int k = 0; k < IW - 1; k++) r[6 + 2*k + ((i >> k) & 1)] ^= 1'b1;
          if (((i >> (IW - 1)) & 1) == 1) r[RW-1] ^= 1'b1;
        end
      end
    end
    return r;
  endfunction

  function automatic logic [SW-1:0] ref_store(input logic [RW-1:0] r);
    logic [SW-1:0] s;
    for (int p = 0; p < SW; p++) begin
      if (p >= 2 && (p - 2) < RW) s[p] = ~r[p-2];
      else                        s[p] = 1'b1;
    end
    return s;
  endfunction

  // Feed the chunk (optionally with ignored bytes between), then check
  // latency, raw and storage results and the emitted byte sequence.
  task automatic run_chunk(input bit rd, input bit gaps, output logic [RW-1:0] got);
    logic [RW-1:0] exp_raw;
    logic [SW-1:0] exp_st;
    int lat;
    exp_raw = ref_raw();
    exp_st  = ref_store(exp_raw);
    for (int i = 0; i < CB; i++) begin
      if (gaps) begin
        seed = rnd(seed);
        if (seed[0]) begin
          @(negedge clk);
          in_valid = 1'b1; ecc_en = 1'b0; in_data = seed[15:8];
        end
        if (seed[1]) begin
          @(negedge clk);
          in_valid = 1'b0; ecc_en = 1'b1; in_data = seed[23:16];
        end
      end
      @(negedge clk);
      in_valid = 1'b1; ecc_en = 1'b1; in_data = chunk[i]; dir_rd = rd;
    end
    lat = 0;
    while (lat < 20) begin
      @(negedge clk);
      in_valid = 1'b0;
      lat++;
      if (res_done) break;
    end
    n_chunks++;
    if (rd) check(lat == 1, "R8 read latency", 64'(lat), 64'd1);
    else    check(lat == WL + 1, "R9 write latency", 64'(lat), 64'(WL + 1));
    check(res_raw == exp_raw, "R2/R3 raw parity", 64'(res_raw), 64'(exp_raw));
    check(res_store == exp_st, "R4 storage word", 64'(res_store), 64'(exp_st));
    got = res_raw;
    for (int b = 0; b < SB; b++) begin
      @(negedge clk);
      check(code_valid && code_byte == exp_st[SW-1-8*b -: 8] &&
            code_last == (b == SB - 1), "R5 emitted byte",
            {55'd0, code_valid, code_byte}, {56'd1, exp_st[SW-1-8*b -: 8]});
    end
    @(negedge clk);
    check(!code_valid && !res_done, "R5/R1 quiet after emission",
          {62'd0, code_valid, res_done}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [RW-1:0] got;
    bit distinct;
    repeat (3) @(negedge clk);
    check(!res_done && !code_valid && !code_last, "R11 in reset",
          {61'd0, res_done, code_valid, code_last}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!res_done && !code_valid && !code_last, "R11 after reset",
          {61'd0, res_done, code_valid, code_last}, 64'd0);

    // All-zero chunk: raw 0, storage all ones (R4).
    for (int i = 0; i < CB; i++) chunk[i] = 8'h00;
    run_chunk(1'b1, 1'b0, got);
    // All-ones chunk in the write direction.
    for (int i = 0; i < CB; i++) chunk[i] = 8'hFF;
    run_chunk(1'b0, 1'b0, got);

    // Exhaustive single-bit sweep (R10), alternating directions.
    for (int p = 0; p < 8 * CB; p++) begin
      for (int i = 0; i < CB; i++) chunk[i] = 8'h00;
      chunk[p / 8][p % 8] = 1'b1;
      run_chunk(p[0], 1'b0, got);
      sweep[p] = got;
    end
    distinct = 1'b1;
    for (int a = 0; a < 8 * CB; a++) begin
      if (sweep[a] == '0) distinct = 1'b0;
      for (int b = a + 1; b < 8 * CB; b++) if (sweep[a] == sweep[b]) distinct = 1'b0;
    end
    check(distinct, "R10 single-bit syndromes distinct", 64'(distinct), 64'd1);

    // Random chunks with ignored bytes interleaved (R7).
    for (int c = 0; c < 40; c++) begin
      for (int i = 0; i < CB; i++) begin
        seed = rnd(seed);
        chunk[i] = seed[7:0];
      end
      run_chunk(c[1], 1'b1, got);
    end

    // Clear mid-chunk (R6): partial bytes and the byte under clr vanish.
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      seed = rnd(seed);
      in_valid = 1'b1; ecc_en = 1'b1; in_data = seed[7:0];
    end
    @(negedge clk);
    clr = 1'b1; in_data = 8'hA5;
    @(negedge clk);
    clr = 1'b0; in_valid = 1'b0;
    check(!res_done, "R6 no release on clear", 64'(res_done), 64'd0);
    for (int i = 0; i < CB; i++) begin
      seed = rnd(seed);
      chunk[i] = seed[7:0];
    end
    run_chunk(1'b1, 1'b0, got);

    // Exactly one release per chunk (R1).
    check(n_done == n_chunks, "R1 one release per chunk", 64'(n_done), 64'(n_chunks));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule